// File: doc/BRIEF.md
# Address-Masked GPIO Data Register

This block is the data register of an 8-bit general-purpose I/O port on a plain memory-mapped bus. Software does not need a read-modify-write to touch single pins. A field of the access address selects which pins an access may affect. A write changes only the selected output bits. A read returns the pad levels of the selected pins and zero for all others. All 256 mask values reach the same register, so each mask has its own alias address.

The select field starts two bits above the address LSB, so each alias is word aligned. Address bit `k+2` governs data bit `k`. The byte-offset bits below the field have no effect. Writes are captured on the rising clock edge when the write enable is high. Reads are combinational from a synchronized copy of the pad input vector, not from the output register. A pad change therefore appears on the read port a fixed number of clock edges later.

Top module: `masked_gpio_port`

## Requirements
- R1: The access mask is address bits [9:2]. Address bit k+2 selects data bit k, for k = 0..7.
- R2: On a rising edge with `wr_en` high, every output bit whose mask bit is 1 takes the value of the matching `wr_data` bit.
- R3: On a write, every output bit whose mask bit is 0 keeps its previous value. For example, writing 0xEB at address 0x098 (mask 0x26) sets bit 1 to 1, bit 2 to 0 and bit 5 to 1, and leaves the other bits unchanged.
- R4: On a read, every bit whose mask bit is 0 returns 0, whatever the pad level.
- R5: On a read, every bit whose mask bit is 1 returns the synchronized pad level. For example, address 0x0C4 (mask 0x31) can return nonzero values only in bits 0, 4 and 5.
- R6: Address bits [1:0] do not affect either the write result or the read result.
- R7: A write with mask 0x00 leaves `data_out` unchanged, and a read with mask 0x00 returns 0x00.
- R8: While `rst_n` is low, `data_out` is 0x00, and the pad synchronizer holds 0x00.
- R9: A pad change becomes visible on `rd_data` after exactly SYNC_STAGES rising edges (2 by default), and not before.
- R10: With `wr_en` low, `data_out` does not change, whatever the address and write data.
- R11: `rd_data` reflects the pads, not `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Access address; bits [9:2] form the pin mask |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Masked read data from the synchronized pads |
| pad_in | input | 8 | Pad input levels |
| data_out | output | 8 | Output data register |

## Verification
The bench builds the block with its defaults: 8 data bits, a mask field starting at address bit 2, and a two-stage pad synchronizer. With a 10-bit address, the full mask space and both byte-offset bits can be driven directly. With the two-stage depth, the bench can check the read latency as one edge too early and exactly on time. The vector table covers the two worked mask examples, the all-ones and all-zeros masks, and aliases that differ only in the low address bits. Directed cases then cover reset, an idle strobe, and pads that disagree with the output register.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int GPIO_DW_DEF    = 8;
  localparam int GPIO_SEL_LSB   = 2;
  localparam int GPIO_SYNC_DEF  = 2;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int DATA_W = gpio_mask_pkg::GPIO_DW_DEF,
  parameter int STAGES = gpio_mask_pkg::GPIO_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pins_raw,
  output logic [DATA_W-1:0] pins_sync
);
  logic [DATA_W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= pins_raw;
        end
        a_r9_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> stage_q[0] == $past(pins_raw));
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
        a_r9_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> stage_q[s] == $past(stage_q[s-1]));
      end
    end
  endgenerate

  assign pins_sync = stage_q[STAGES-1];

  // R8: synchronizer output is cleared while reset is held
  a_r8_sync_clear: assert property (@(negedge clk) !rst_n |-> pins_sync == '0);
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int DATA_W = gpio_mask_pkg::GPIO_DW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] sel_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] out_q
);
  // Bitwise merge: selected bits from fresh, the others from held
  function automatic logic [DATA_W-1:0] merge_sel(
    input logic [DATA_W-1:0] held,
    input logic [DATA_W-1:0] fresh,
    input logic [DATA_W-1:0] sel
  );
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = sel[i] ? fresh[i] : held[i];
    return r;
  endfunction

  logic [DATA_W-1:0] wr_bits;   // bits actually written this cycle
  logic [DATA_W-1:0] out_next;

  assign wr_bits  = wr_en ? sel_mask : '0;
  assign out_next = merge_sel(out_q, wr_data, wr_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_next;
  end

  a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (out_q & $past(sel_mask)) == ($past(wr_data) & $past(sel_mask)));
  a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((out_q ^ $past(out_q)) & ~$past(sel_mask)) == '0);
  a_r7_empty_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0) |=> $stable(out_q));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_q));
  a_r8_out_clear: assert property (@(negedge clk) !rst_n |-> out_q == '0);
endmodule

// File: rtl/gpio_rd_gate.sv
module gpio_rd_gate #(
  parameter int DATA_W = gpio_mask_pkg::GPIO_DW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sel_mask,
  input  logic [DATA_W-1:0] pins_sync,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [DATA_W-1:0] gate_sel(
    input logic [DATA_W-1:0] val,
    input logic [DATA_W-1:0] sel
  );
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = sel[i] & val[i];
    return r;
  endfunction

  assign rd_data = gate_sel(pins_sync, sel_mask);

  a_r4_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~sel_mask) == '0);
  a_r7_empty_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mask == '0) |-> rd_data == '0);
  a_r5_selected_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data | ~sel_mask) == (pins_sync | ~sel_mask));
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port #(
  parameter  int DATA_W   = gpio_mask_pkg::GPIO_DW_DEF,
  parameter  int SEL_LSB  = gpio_mask_pkg::GPIO_SEL_LSB,
  parameter  int SYNC_STG = gpio_mask_pkg::GPIO_SYNC_DEF,
  localparam int ADDR_W   = SEL_LSB + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] data_out
);
  // R1: address bit k+SEL_LSB selects data bit k
  function automatic logic [DATA_W-1:0] addr_to_sel(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < DATA_W; k++) m[k] = a[k + SEL_LSB];
    return m;
  endfunction

  logic [DATA_W-1:0] acc_sel;     // per-pin access mask
  logic [DATA_W-1:0] pins_sync;   // synchronized pad levels

  assign acc_sel = addr_to_sel(addr);

  generate
    if (SEL_LSB > 0) begin : g_lo
      logic unused_lo;            // R6: byte-offset bits take no part
      assign unused_lo = ^addr[SEL_LSB-1:0];
    end
  endgenerate

  gpio_pin_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_raw(pad_in), .pins_sync(pins_sync)
  );

  gpio_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_mask(acc_sel),
    .wr_data(wr_data), .out_q(data_out)
  );

  gpio_rd_gate #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel_mask(acc_sel), .pins_sync(pins_sync),
    .rd_data(rd_data)
  );

  a_r1_sel_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    addr[SEL_LSB] |-> acc_sel[0]);
  a_r1_sel_msb: assert property (@(posedge clk) disable iff (!rst_n)
    !addr[ADDR_W-1] |-> !acc_sel[DATA_W-1]);
endmodule

// File: tb/sim_masked_gpio_port.sv
module sim_masked_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] rd_data, data_out;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_out = '0;

  always #2.5 clk = ~clk;   // 200 MHz

  masked_gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .data_out(data_out)
  );

  // {addr, wr_data, pad}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {10'h098, 8'hEB, 8'hFF},   // worked write example, mask 0x26
    {10'h0C4, 8'h00, 8'hFF},   // worked read example, mask 0x31
    {10'h3FC, 8'hA5, 8'h5A},   // all bits selected
    {10'h000, 8'hFF, 8'hFF},   // empty mask
    {10'h3FF, 8'h3C, 8'hC3},   // low bits set, all selected
    {10'h099, 8'h00, 8'h0F},   // alias of 0x098 with offset 1
    {10'h0C7, 8'hFF, 8'hF0},   // alias of 0x0C4 with offset 3
    {10'h204, 8'h81, 8'h81}    // ends only
  };

  function automatic logic [7:0] sel_of(input logic [9:0] a);
    return a[9:2];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
    for (int b = 0; b < 8; b++) if (a[b+2]) model_out[b] = d[b];
  endtask

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(2);
    check("R8 reset data_out", data_out, 8'h00);
    addr = 10'h3FC; pad_in = 8'hFF;
    tick(3);
    check("R8 sync held in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    pad_in = 8'h00;
    tick(3);

    for (int v = 0; v < NV; v++) begin
      logic [9:0] a; logic [7:0] d, p;
      {a, d, p} = VEC[v];
      do_write(a, d);
      check("R2 R3 R7 vector write", data_out, model_out);
      pad_in = p;
      tick(2);
      check("R4 R5 R6 vector read", rd_data, p & sel_of(a));
    end

    // R3 explicit worked example from zero
    rst_n = 1'b0; tick(1); rst_n = 1'b1; model_out = '0; tick(1);
    check("R8 reset mid-run", data_out, 8'h00);
    do_write(10'h098, 8'hEB);
    check("R3 example write 0x098", data_out, 8'h22);

    // R10 strobe low
    addr = 10'h3FC; wr_data = 8'h55; wr_en = 1'b0;
    tick(2);
    check("R10 idle no change", data_out, 8'h22);

    // R7 empty mask
    do_write(10'h003, 8'hFF);
    check("R7 empty mask write", data_out, 8'h22);

    // R1 single bit positions
    for (int b = 0; b < 8; b++) begin
      logic [9:0] a;
      a = 10'(1) << (b + 2);
      do_write(a, 8'hFF);
      check("R1 single select write", data_out, model_out);
    end

    // R9 latency and R11 pads vs output
    addr = 10'h3FC; pad_in = 8'h00; tick(3);
    pad_in = 8'hA5;
    tick(1);
    check("R9 not visible after one edge", rd_data, 8'h00);
    tick(1);
    check("R9 visible after two edges", rd_data, 8'hA5);
    pad_in = 8'h00; tick(2);
    check("R11 read shows pads not output", rd_data, 8'h00);
    check("R11 output still set", data_out, 8'hFF);

    // R6 read aliases
    pad_in = 8'hFF; tick(2);
    for (int lo = 0; lo < 4; lo++) begin
      addr = {8'h31, 2'(lo)};
      #1;
      check("R6 R5 alias read 0x0C4", rd_data, 8'h31);
    end
    addr = 10'h000; #1;
    check("R7 empty mask read", rd_data, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule